// File: doc/BRIEF.md
# SDRAM Burst Termination Controller

This block turns single-cycle host requests into commands on an SDRAM command bus. It opens rows and issues read and write bursts of a fixed length. A burst can be ended early in two ways: with a burst-stop command, or by closing the bank with a precharge. The block drives the command code, the bank number, the byte mask (DQM) and the outgoing data lanes with their output enable. It also raises a read-valid strobe for each read word that the device will really return, so the host collects exactly the valid words when a burst is cut short.

Every bus output is registered, so the bus reflects a host request one clock after the request. CAS latency is chosen at run time from a configuration input, which must only change while the block is idle. Burst length, the minimum row-active time (active to precharge) and the write-recovery time (last write data to precharge) are parameters. A precharge that would break either timing rule is held back and issued on the first legal cycle. During that wait a read burst keeps running, and write beats are masked.

The controller is built around five states. `ST_IDLE` accepts activate, read, write and precharge requests. `ST_READ` and `ST_WRITE` run the remaining beats of a burst. `ST_PREWAIT` holds a deferred precharge, while any read beats that are left keep being issued. `ST_WMASK` holds a deferred precharge that ended a write, with DQM high. The transitions are:
- idle→read on a read request, and idle→write on a write request.
- read→idle and write→idle on the last beat, on a stop, or on a precharge that is legal at once.
- idle→prewait and read→prewait on a precharge that is not yet legal.
- write→wmask on a precharge that is not yet legal.
- prewait→idle and wmask→idle when the precharge is issued.

Top module: `sdram_bt_ctrl`

## Requirements
- R1: After reset, and on every cycle with no command, the bus carries NOP (code 0), DQM low and output enable low, and `host_rvalid` is low.
- R2: Command codes are NOP=0, ACT=1, RD=2, WR=3, BST=4, PRE=5. An accepted ACT, RD or WR request appears on `sdram_cmd` one clock later, with the request's bank on `sdram_bank`.
- R3: A write burst that is not interrupted drives BL consecutive beats with output enable high and DQM low, starting with the WR cycle. Each beat carries the `host_wdata` sampled one clock earlier.
- R4: A stop during a write replaces the current beat with BST, with DQM high and output enable low. The last written word is on the bus exactly one clock before BST.
- R5: Each read beat issued on the bus (the RD cycle and each later burst cycle) makes `host_rvalid` high exactly `cfg_cl` clocks later. `cfg_cl` is 2 or 3. A full read gives BL strobes.
- R6: A stop issued at beat index p of a read (1 ≤ p < BL) gives exactly p strobes. When p ≥ `cfg_cl`−1, `cfg_cl`−1 of those strobes come after the BST cycle.
- R7: PRE to a bank never reaches the bus fewer than TRAS clocks after ACT to that bank. A request that comes too early is held and issued on the first legal clock.
- R8: A precharge during a read ends the burst in the same way as a stop. Read beats continue while the precharge waits on R7, and they end on the PRE cycle.
- R9: A precharge during a write holds DQM high and output enable low from the requested beat through the PRE cycle. PRE comes no sooner than TRDL clocks after the last written beat.
- R10: Activate, read or write requests made during a burst are ignored, and so is a stop request while idle. The bus output is unchanged by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cl | input | CLW | CAS latency, 2..MAXCL |
| host_act | input | 1 | Open a row in `host_bank` |
| host_rd | input | 1 | Start a read burst |
| host_wr | input | 1 | Start a write burst |
| host_stop | input | 1 | End the running burst with a burst stop |
| host_pre | input | 1 | Close the bank (ends a running burst) |
| host_bank | input | BW | Bank for the request |
| host_wdata | input | DW | Write word for the current beat |
| host_rvalid | output | 1 | Read word on `host_rdata` is valid |
| host_rdata | output | DW | Read word from the device lanes |
| sdram_cmd | output | 3 | Bus command code |
| sdram_bank | output | BW | Bus bank number |
| sdram_dqm | output | 1 | Data mask |
| sdram_dq_out | output | DW | Outgoing write word |
| sdram_dq_oe | output | 1 | Output enable for the data lanes |
| sdram_dq_in | input | DW | Incoming read word |

## Verification
The bench builds the block with BL=4, TRAS=6, TRDL=2, four banks and 16-bit data, and runs at both CAS latencies. With TRAS=6 and BL=4, a precharge requested right after ACT has to wait beyond the burst end, which shows that read beats continue and that write beats stay masked during the hold. TRDL=2 means a write precharge requested at a beat always lands one clock later than requested. Stop points at beat 2 and beat 3 give residual read counts of both 1 and 2.

// File: rtl/sdram_bt_pkg.sv
package sdram_bt_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_BST = 3'd4,
        CMD_PRE = 3'd5
    } bus_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_PREWAIT,
        ST_WMASK
    } ctl_state_e;

endpackage

// File: rtl/sdram_bt_tras.sv
module sdram_bt_tras #(
    parameter int NBANK = 4,
    parameter int TRAS  = 6,
    localparam int BW   = $clog2(NBANK),
    localparam int CW   = $clog2(TRAS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_fire,
    input  logic [BW-1:0]    act_bank,
    output logic [NBANK-1:0] ras_ok
);

    localparam logic [CW-1:0] LOADV = CW'(TRAS - 1);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [CW-1:0] cnt_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (act_fire && act_bank == BW'(b)) begin
                cnt_q <= LOADV;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end

        assign ras_ok[b] = (cnt_q == '0);
    end

endmodule

// File: rtl/sdram_bt_beats.sv
module sdram_bt_beats #(
    parameter int BL   = 4,
    parameter int TRDL = 2,
    localparam int BCW = $clog2(BL),
    localparam int GW  = $clog2(TRDL + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic           clear,
    input  logic           wbeat,
    output logic [BCW-1:0] beats_left,
    output logic           rdl_ok
);

    localparam logic [BCW-1:0] BLAST = BCW'(BL - 1);
    localparam logic [GW-1:0]  GMAX  = GW'(TRDL);

    logic [BCW-1:0] left_q;
    logic [GW-1:0]  gap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= BLAST;
        end else if (clear) begin
            left_q <= '0;
        end else if (step && left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= GMAX;
        end else if (wbeat) begin
            gap_q <= '0;
        end else if (gap_q < GMAX) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assign beats_left = left_q;
    assign rdl_ok     = (gap_q >= GMAX - 1'b1);

endmodule

// File: rtl/sdram_bt_rdpipe.sv
module sdram_bt_rdpipe #(
    parameter int MAXCL = 3,
    localparam int CLW  = $clog2(MAXCL + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           slot,
    input  logic [CLW-1:0] cl,
    output logic           rvalid
);

    logic [MAXCL-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[MAXCL-2:0], slot};
        end
    end

    always_comb begin
        rvalid = 1'b0;
        for (int i = 1; i <= MAXCL; i++) begin
            if (cl == CLW'(i)) begin
                rvalid = sh_q[i-1];
            end
        end
    end

endmodule

// File: rtl/sdram_bt_ctrl.sv
module sdram_bt_ctrl
    import sdram_bt_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int DW    = 16,
    parameter int BL    = 4,
    parameter int MAXCL = 3,
    parameter int TRAS  = 6,
    parameter int TRDL  = 2,
    localparam int BW   = $clog2(NBANK),
    localparam int CLW  = $clog2(MAXCL + 1),
    localparam int BCW  = $clog2(BL)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CLW-1:0] cfg_cl,
    input  logic           host_act,
    input  logic           host_rd,
    input  logic           host_wr,
    input  logic           host_stop,
    input  logic           host_pre,
    input  logic [BW-1:0]  host_bank,
    input  logic [DW-1:0]  host_wdata,
    output logic           host_rvalid,
    output logic [DW-1:0]  host_rdata,
    output logic [2:0]     sdram_cmd,
    output logic [BW-1:0]  sdram_bank,
    output logic           sdram_dqm,
    output logic [DW-1:0]  sdram_dq_out,
    output logic           sdram_dq_oe,
    input  logic [DW-1:0]  sdram_dq_in
);

    ctl_state_e st_q, st_d;
    bus_cmd_e   cmd_q, cmd_d;
    logic [BW-1:0]    bank_q, bank_d;
    logic             dqm_q, dqm_d;
    logic             oe_q, oe_d;
    logic [DW-1:0]    data_q, data_d;
    logic             slot_q, slot_d;
    logic             act_fire, load, step, clear, wbeat;
    logic [NBANK-1:0] ras_ok;
    logic [BCW-1:0]   beats_left;
    logic             rdl_ok;
    logic             pre_ok, pre_ok_host;

    sdram_bt_tras #(.NBANK(NBANK), .TRAS(TRAS)) u_tras (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_fire (act_fire),
        .act_bank (bank_d),
        .ras_ok   (ras_ok)
    );

    sdram_bt_beats #(.BL(BL), .TRDL(TRDL)) u_beats (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .clear      (clear),
        .wbeat      (wbeat),
        .beats_left (beats_left),
        .rdl_ok     (rdl_ok)
    );

    sdram_bt_rdpipe #(.MAXCL(MAXCL)) u_rdpipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .slot   (slot_q),
        .cl     (cfg_cl),
        .rvalid (host_rvalid)
    );

    assign pre_ok      = ras_ok[bank_q] && rdl_ok;
    assign pre_ok_host = ras_ok[host_bank] && rdl_ok;

    // State register and registered bus outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cmd_q  <= CMD_NOP;
            bank_q <= '0;
            dqm_q  <= 1'b0;
            oe_q   <= 1'b0;
            data_q <= '0;
            slot_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cmd_q  <= cmd_d;
            bank_q <= bank_d;
            dqm_q  <= dqm_d;
            oe_q   <= oe_d;
            data_q <= data_d;
            slot_q <= slot_d;
        end
    end

    // Next state and next bus values
    always_comb begin
        st_d     = st_q;
        cmd_d    = CMD_NOP;
        bank_d   = bank_q;
        dqm_d    = 1'b0;
        oe_d     = 1'b0;
        slot_d   = 1'b0;
        act_fire = 1'b0;
        load     = 1'b0;
        step     = 1'b0;
        clear    = 1'b0;
        wbeat    = 1'b0;

        unique case (st_q)
            ST_IDLE: begin
                if (host_act) begin
                    cmd_d    = CMD_ACT;
                    bank_d   = host_bank;
                    act_fire = 1'b1;
                end else if (host_rd) begin
                    cmd_d  = CMD_RD;
                    bank_d = host_bank;
                    slot_d = 1'b1;
                    load   = 1'b1;
                    st_d   = ST_READ;
                end else if (host_wr) begin
                    cmd_d  = CMD_WR;
                    bank_d = host_bank;
                    oe_d   = 1'b1;
                    wbeat  = 1'b1;
                    load   = 1'b1;
                    st_d   = ST_WRITE;
                end else if (host_pre) begin
                    bank_d = host_bank;
                    if (pre_ok_host) begin
                        cmd_d = CMD_PRE;
                    end else begin
                        clear = 1'b1;
                        st_d  = ST_PREWAIT;
                    end
                end
            end

            ST_READ: begin
                if (host_stop) begin
                    cmd_d = CMD_BST;
                    st_d  = ST_IDLE;
                end else if (host_pre && pre_ok) begin
                    cmd_d = CMD_PRE;
                    st_d  = ST_IDLE;
                end else begin
                    slot_d = 1'b1;
                    step   = 1'b1;
                    if (host_pre) begin
                        st_d = ST_PREWAIT;
                    end else if (beats_left == BCW'(1)) begin
                        st_d = ST_IDLE;
                    end
                end
            end

            ST_WRITE: begin
                if (host_stop) begin
                    cmd_d = CMD_BST;
                    dqm_d = 1'b1;
                    st_d  = ST_IDLE;
                end else if (host_pre) begin
                    dqm_d = 1'b1;
                    if (pre_ok) begin
                        cmd_d = CMD_PRE;
                        st_d  = ST_IDLE;
                    end else begin
                        st_d = ST_WMASK;
                    end
                end else begin
                    oe_d  = 1'b1;
                    wbeat = 1'b1;
                    step  = 1'b1;
                    if (beats_left == BCW'(1)) begin
                        st_d = ST_IDLE;
                    end
                end
            end

            ST_PREWAIT: begin
                if (pre_ok) begin
                    cmd_d = CMD_PRE;
                    st_d  = ST_IDLE;
                end else if (beats_left != '0) begin
                    slot_d = 1'b1;
                    step   = 1'b1;
                end
            end

            ST_WMASK: begin
                dqm_d = 1'b1;
                if (pre_ok) begin
                    cmd_d = CMD_PRE;
                    st_d  = ST_IDLE;
                end
            end
        endcase

        data_d = oe_d ? host_wdata : '0;
    end

    assign sdram_cmd    = cmd_q;
    assign sdram_bank   = bank_q;
    assign sdram_dqm    = dqm_q;
    assign sdram_dq_oe  = oe_q;
    assign sdram_dq_out = data_q;
    assign host_rdata   = sdram_dq_in;

endmodule

// File: rtl/sdram_bt_chk.sv
module sdram_bt_chk
    import sdram_bt_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int BL    = 4,
    parameter int MAXCL = 3,
    parameter int TRAS  = 6,
    parameter int TRDL  = 2,
    localparam int BW   = $clog2(NBANK),
    localparam int CLW  = $clog2(MAXCL + 1),
    localparam int AW   = $clog2(TRAS + 1),
    localparam int WW   = $clog2(TRDL + 1),
    localparam int RLIM = BL + MAXCL,
    localparam int RW   = $clog2(RLIM + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic [CLW-1:0] cfg_cl,
    input logic [2:0]     sdram_cmd,
    input logic [BW-1:0]  sdram_bank,
    input logic           sdram_dqm,
    input logic           sdram_dq_oe,
    input logic           host_rvalid
);

    logic [AW-1:0] since_act [NBANK];
    logic [WW-1:0] since_wr;
    logic [RW-1:0] since_rd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NBANK; b++) since_act[b] <= AW'(TRAS);
            since_wr <= WW'(TRDL);
            since_rd <= RW'(RLIM);
        end else begin
            for (int b = 0; b < NBANK; b++) begin
                if (sdram_cmd == CMD_ACT && sdram_bank == BW'(b))
                    since_act[b] <= AW'(1);
                else if (int'(since_act[b]) < TRAS)
                    since_act[b] <= since_act[b] + 1'b1;
            end
            if (sdram_dq_oe) since_wr <= WW'(1);
            else if (int'(since_wr) < TRDL) since_wr <= since_wr + 1'b1;
            if (sdram_cmd == CMD_RD) since_rd <= RW'(1);
            else if (int'(since_rd) < RLIM) since_rd <= since_rd + 1'b1;
        end
    end

    p_oe_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sdram_dq_oe |-> !sdram_dqm);

    p_wr_carries_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sdram_cmd == CMD_WR) |-> sdram_dq_oe);

    p_term_no_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sdram_cmd == CMD_BST || sdram_cmd == CMD_PRE) |-> !sdram_dq_oe);

    p_tras_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sdram_cmd == CMD_PRE) |-> (int'(since_act[sdram_bank]) >= TRAS));

    p_rdl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sdram_cmd == CMD_PRE) |-> (int'(since_wr) >= TRDL));

    p_rvalid_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> (int'(since_rd) <= BL - 1 + MAXCL));

    p_rvalid_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> (int'(cfg_cl) >= 2 && int'(cfg_cl) <= MAXCL));

endmodule

bind sdram_bt_ctrl sdram_bt_chk #(
    .NBANK (NBANK),
    .BL    (BL),
    .MAXCL (MAXCL),
    .TRAS  (TRAS),
    .TRDL  (TRDL)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_cl      (cfg_cl),
    .sdram_cmd   (sdram_cmd),
    .sdram_bank  (sdram_bank),
    .sdram_dqm   (sdram_dqm),
    .sdram_dq_oe (sdram_dq_oe),
    .host_rvalid (host_rvalid)
);

// File: tb/sdram_bt_ctrl_test.sv
module sdram_bt_ctrl_test;

    localparam int NBANK = 4;
    localparam int DW    = 16;
    localparam int BL    = 4;
    localparam int MAXCL = 3;
    localparam int TRAS  = 6;
    localparam int TRDL  = 2;

    localparam int K_ACT = 0, K_RD = 1, K_WR = 2, K_PRE = 3, K_STOP = 4;
    localparam int T_NONE = 0, T_STOP = 1, T_PRE = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_cl = 2'd2;
    logic          host_act = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
    logic          host_stop = 1'b0, host_pre = 1'b0;
    logic [1:0]    host_bank = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_rvalid;
    logic [DW-1:0] host_rdata;
    logic [2:0]    sdram_cmd;
    logic [1:0]    sdram_bank;
    logic          sdram_dqm;
    logic [DW-1:0] sdram_dq_out;
    logic          sdram_dq_oe;
    logic [DW-1:0] sdram_dq_in = 16'h5A5A;

    sdram_bt_ctrl #(
        .NBANK(NBANK), .DW(DW), .BL(BL), .MAXCL(MAXCL), .TRAS(TRAS), .TRDL(TRDL)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cfg_cl(cfg_cl),
        .host_act(host_act), .host_rd(host_rd), .host_wr(host_wr),
        .host_stop(host_stop), .host_pre(host_pre), .host_bank(host_bank),
        .host_wdata(host_wdata), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
        .sdram_cmd(sdram_cmd), .sdram_bank(sdram_bank), .sdram_dqm(sdram_dqm),
        .sdram_dq_out(sdram_dq_out), .sdram_dq_oe(sdram_dq_oe), .sdram_dq_in(sdram_dq_in)
    );

    always #2 clk = ~clk;

    typedef struct packed {
        logic [2:0]    cmd;
        logic [1:0]    bank;
        logic          dqm;
        logic          oe;
        logic [DW-1:0] data;
        logic          rv;
    } item_t;

    item_t expq[$];
    string tagq[$];
    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    int    rvcnt = 0;
    int    act_t[NBANK];
    int    opid = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input string what, input int got, input int expv);
        checks++;
        if (got != expv) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, got, expv);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Monitor: pops one expected bus item per cycle, counts read strobes
    always @(posedge clk) begin
        item_t it;
        string tg;
        #1;
        if (host_rvalid) rvcnt++;
        if (expq.size() != 0) begin
            it = expq.pop_front();
            tg = tagq.pop_front();
            chk(tg, "cmd", int'(sdram_cmd), int'(it.cmd));
            if (it.cmd != 3'd0) chk(tg, "bank", int'(sdram_bank), int'(it.bank));
            chk(tg, "dqm", int'(sdram_dqm), int'(it.dqm));
            chk(tg, "oe", int'(sdram_dq_oe), int'(it.oe));
            if (it.oe) chk(tg, "data", int'(sdram_dq_out), int'(it.data));
            chk(tg, "rvalid", int'(host_rvalid), int'(it.rv));
        end
    end

    // Driver: computes the expected bus trace, queues it, then drives the request
    task automatic run_op(input int kind, input int term, input int p,
                          input int bank, input bit noise, input string tag);
        item_t e[40];
        int s, q, n, len, cl;
        cl = int'(cfg_cl);
        opid++;
        @(negedge clk);
        s = cyc + 1;
        n = 0;
        len = 1;
        for (int i = 0; i < 40; i++) e[i] = '{cmd: 3'd0, bank: 2'(bank), dqm: 1'b0,
                                               oe: 1'b0, data: '0, rv: 1'b0};
        case (kind)
            K_ACT: begin
                e[0].cmd = 3'd1;
                act_t[bank] = s;
            end
            K_RD: begin
                e[0].cmd = 3'd2;
                n = BL;
                if (term == T_STOP) begin
                    n = p;
                    e[p].cmd = 3'd4;
                    len = p + 1;
                end else if (term == T_PRE) begin
                    q = imax(p, act_t[bank] + TRAS - s);
                    n = (q < BL) ? q : BL;
                    e[q].cmd = 3'd5;
                    len = q + 1;
                end
                for (int k = 0; k < n; k++) e[k + cl].rv = 1'b1;
                len = imax(len, n - 1 + cl + 1);
            end
            K_WR: begin
                n = BL;
                if (term == T_STOP) begin
                    n = p;
                    e[p].cmd = 3'd4;
                    e[p].dqm = 1'b1;
                end else if (term == T_PRE) begin
                    n = p;
                    q = imax(imax(p, p - 1 + TRDL), act_t[bank] + TRAS - s);
                    for (int k = p; k <= q; k++) e[k].dqm = 1'b1;
                    e[q].cmd = 3'd5;
                    len = q + 1;
                end
                for (int k = 0; k < n; k++) begin
                    e[k].oe = 1'b1;
                    e[k].data = {8'(opid), 8'(k)};
                end
                e[0].cmd = 3'd3;
                len = imax(len, (term == T_STOP) ? p + 1 : n);
            end
            K_PRE: begin
                q = imax(0, act_t[bank] + TRAS - s);
                e[q].cmd = 3'd5;
                len = q + 1;
            end
            default: begin
                len = 2;
            end
        endcase
        for (int i = 0; i < len; i++) begin
            expq.push_back(e[i]);
            tagq.push_back(tag);
        end
        rvcnt = 0;
        for (int i = 0; i < len; i++) begin
            if (i != 0) @(negedge clk);
            host_act = 1'b0; host_rd = 1'b0; host_wr = 1'b0;
            host_stop = 1'b0; host_pre = 1'b0;
            host_bank = 2'(bank);
            host_wdata = {8'(opid), 8'(i)};
            if (i == 0) begin
                case (kind)
                    K_ACT:   host_act = 1'b1;
                    K_RD:    host_rd = 1'b1;
                    K_WR:    host_wr = 1'b1;
                    K_PRE:   host_pre = 1'b1;
                    default: host_stop = 1'b1;
                endcase
            end
            if (i == p && i != 0) begin
                if (term == T_STOP) host_stop = 1'b1;
                if (term == T_PRE) host_pre = 1'b1;
            end
            if (noise && i == 1) begin
                host_act = 1'b1; host_rd = 1'b1; host_wr = 1'b1;
            end
        end
        @(negedge clk);
        host_act = 1'b0; host_rd = 1'b0; host_wr = 1'b0;
        host_stop = 1'b0; host_pre = 1'b0;
        wait (expq.size() == 0);
        @(negedge clk);
        if (kind == K_RD) chk(tag, "read beat count", rvcnt, n);
    endtask

    initial begin
        #(4 * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int b = 0; b < NBANK; b++) act_t[b] = -1000;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "cmd after reset", int'(sdram_cmd), 0);
        chk("R1", "dqm after reset", int'(sdram_dqm), 0);
        chk("R1", "oe after reset", int'(sdram_dq_oe), 0);
        chk("R1", "rvalid after reset", int'(host_rvalid), 0);

        // CAS latency 2
        cfg_cl = 2'd2;
        run_op(K_ACT, T_NONE, 0, 1, 1'b0, "R2");
        run_op(K_WR,  T_NONE, 0, 1, 1'b0, "R3");
        run_op(K_RD,  T_NONE, 0, 1, 1'b0, "R5");
        run_op(K_RD,  T_STOP, 2, 1, 1'b0, "R6");
        run_op(K_WR,  T_STOP, 3, 1, 1'b0, "R4");
        run_op(K_RD,  T_PRE,  2, 1, 1'b0, "R8");
        run_op(K_WR,  T_PRE,  2, 1, 1'b0, "R9");
        run_op(K_ACT, T_NONE, 0, 2, 1'b0, "R2");
        run_op(K_RD,  T_PRE,  1, 2, 1'b0, "R7");
        run_op(K_RD,  T_NONE, 0, 1, 1'b1, "R10");
        run_op(K_STOP, T_NONE, 0, 1, 1'b0, "R10");

        // CAS latency 3
        repeat (4) @(negedge clk);
        cfg_cl = 2'd3;
        run_op(K_RD,  T_NONE, 0, 1, 1'b0, "R5");
        run_op(K_RD,  T_STOP, 3, 1, 1'b0, "R6");
        run_op(K_RD,  T_STOP, 2, 0, 1'b0, "R6");
        run_op(K_RD,  T_PRE,  2, 1, 1'b0, "R8");
        run_op(K_ACT, T_NONE, 0, 3, 1'b0, "R2");
        run_op(K_WR,  T_PRE,  1, 3, 1'b0, "R9");
        run_op(K_ACT, T_NONE, 0, 0, 1'b0, "R2");
        run_op(K_PRE, T_NONE, 0, 0, 1'b0, "R7");
        run_op(K_WR,  T_NONE, 0, 2, 1'b1, "R10");

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule